// File: doc/BRIEF.md
# Offset-Remapped Circular Word Memory

A single-port 1024 x 16 word memory whose contents can be made to slide by a fixed number of locations in one clock cycle without moving any stored word. The block rebases every host address before it reaches the storage array. A host that wants to discard the lowest block of entries and see the following entries at those addresses issues one shift pulse instead of copying words one by one.

Two mapping modes are selected by a port. In offset mode a 10-bit base register is added to the host address, and the sum wraps at the memory depth. A shift adds a compile-time step (default 60) to that base. In window mode the memory is seen as sixteen 64-word windows. A 4-bit window counter is added only to the top four address bits, while the six low bits pass through unchanged. A shift then steps the counter by one window. Each mode keeps its own base state, so switching modes does not disturb the other mode's position.

Top module: `offset_ring_mem`

## Requirements
- R1: While `rst` is high the offset base and the window counter are cleared and `rd_data` is 0. After reset, logical address A reaches physical location A in both modes.
- R2: With `win_mode`=0, a write or read at logical address A reaches physical location (A + base) mod 1024.
- R3: With `win_mode`=0, a `shift` pulse adds SHIFT_STEP (default 60) to the base. After one shift from base 0, logical address 0 returns the word written earlier at logical 60.
- R4: The base wraps modulo 1024, both when an address is added to it and when a shift is accumulated. For example, 18 shifts of 60 from 0 leave base 56.
- R5: With `win_mode`=1, logical address A reaches physical location {(A[9:6] + win) mod 16, A[5:0]}, and a `shift` increments the window counter `win` by one.
- R6: An access issued in the same cycle as `shift` uses the mapping from before the shift. The new mapping takes effect from the next cycle.
- R7: `rd_data` is registered. It holds the word at the addressed location as it was before any write in the same cycle, one cycle after the address is presented.
- R8: A shift in one mode leaves the other mode's base state unchanged.
- R9: The window counter wraps from 15 to 0, and window-mode addresses wrap modulo 1024 in the same way.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| win_mode | input | 1 | 0 = offset mapping, 1 = window mapping |
| shift | input | 1 | Advance the mapping of the selected mode by one step |
| wr_en | input | 1 | Write `wr_data` at the mapped address |
| addr | input | 10 | Logical word address |
| wr_data | input | 16 | Write data |
| rd_data | output | 16 | Registered read data from the mapped address |

## Verification
The assertions assume that `shift` and `win_mode` are known 0 or 1 on every clock edge after reset. They also assume that the host reads only locations it has already written, because the storage array itself is never cleared. The stimulus drives every input at the falling edge, writes each location before it reads it, and keeps every control line at a defined level from time zero. Expected words follow from hand-computed physical addresses, so each read in the test points at a location whose content is known.

// File: rtl/remap_pkg.sv
package remap_pkg;
    localparam int DEPTH      = 1024;
    localparam int DW         = 16;
    localparam int AW         = $clog2(DEPTH);
    localparam int WIN_WORDS  = 64;
    localparam int LOW_W      = $clog2(WIN_WORDS);
    localparam int WIN_W      = AW - LOW_W;
    localparam int SHIFT_STEP = 60;

    typedef logic [AW-1:0]    addr_t;
    typedef logic [DW-1:0]    data_t;
    typedef logic [WIN_W-1:0] win_t;

    typedef enum logic {MAP_OFFSET = 1'b0, MAP_WINDOW = 1'b1} map_mode_e;

    typedef struct packed {
        logic  wr;
        addr_t addr;
        data_t data;
    } host_req_t;

    // sum truncated to AW bits: natural modulo DEPTH for power-of-two depth
    function automatic addr_t ring_add(addr_t a, addr_t b);
        return a + b;
    endfunction
endpackage

// File: rtl/remap_state.sv
module remap_state
    import remap_pkg::*;
#(
    parameter int STEP = SHIFT_STEP
) (
    input  logic      clk,
    input  logic      rst,
    input  logic      shift,
    input  map_mode_e mode,
    output addr_t     base_q,
    output win_t      win_q
);
    localparam addr_t STEP_A = addr_t'(STEP);

    always_ff @(posedge clk) begin
        if (rst) begin
            base_q <= '0;
            win_q  <= '0;
        end else if (shift) begin
            if (mode == MAP_OFFSET)
                base_q <= ring_add(base_q, STEP_A);
            else
                win_q <= win_q + win_t'(1);
        end
    end
endmodule

// File: rtl/remap_decode.sv
module remap_decode
    import remap_pkg::*;
(
    input  map_mode_e mode,
    input  addr_t     laddr,
    input  addr_t     base,
    input  win_t      win,
    output addr_t     paddr
);
    win_t hi_sum;

    always_comb begin
        hi_sum = laddr[AW-1:LOW_W] + win;
        if (mode == MAP_OFFSET)
            paddr = ring_add(laddr, base);
        else
            paddr = {hi_sum, laddr[LOW_W-1:0]};
    end
endmodule

// File: rtl/word_store.sv
module word_store
    import remap_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  host_req_t req,
    output data_t     rd_q
);
    data_t mem [DEPTH];

    always_ff @(posedge clk) begin
        if (req.wr && !rst)
            mem[req.addr] <= req.data;
    end

    always_ff @(posedge clk) begin
        if (rst)
            rd_q <= '0;
        else
            rd_q <= mem[req.addr];
    end
endmodule

// File: rtl/offset_ring_mem.sv
module offset_ring_mem
    import remap_pkg::*;
#(
    parameter int STEP = SHIFT_STEP
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          win_mode,
    input  logic          shift,
    input  logic          wr_en,
    input  logic [AW-1:0] addr,
    input  logic [DW-1:0] wr_data,
    output logic [DW-1:0] rd_data
);
    map_mode_e mode;
    addr_t     base_q;
    win_t      win_q;
    addr_t     paddr;
    host_req_t req;

    assign mode = map_mode_e'(win_mode);

    remap_state #(.STEP(STEP)) u_state (
        .clk    (clk),
        .rst    (rst),
        .shift  (shift),
        .mode   (mode),
        .base_q (base_q),
        .win_q  (win_q)
    );

    remap_decode u_dec (
        .mode  (mode),
        .laddr (addr),
        .base  (base_q),
        .win   (win_q),
        .paddr (paddr)
    );

    always_comb begin
        req.wr   = wr_en;
        req.addr = paddr;
        req.data = wr_data;
    end

    word_store u_store (
        .clk  (clk),
        .rst  (rst),
        .req  (req),
        .rd_q (rd_data)
    );
endmodule

// File: rtl/offset_ring_mem_chk.sv
module offset_ring_mem_chk
    import remap_pkg::*;
#(
    parameter int STEP = SHIFT_STEP
) (
    input logic          clk,
    input logic          rst,
    input logic          win_mode,
    input logic          shift,
    input addr_t         base_q,
    input win_t          win_q,
    input logic [DW-1:0] rd_data
);
    localparam addr_t STEP_A = addr_t'(STEP);

    assert_reset_clear_R1: assert property (@(posedge clk)
        rst |=> (base_q == '0) && (win_q == '0) && (rd_data == '0));

    assert_base_step_R3: assert property (@(posedge clk) disable iff (rst)
        (shift && !win_mode) |=> base_q == $past(base_q) + STEP_A);

    assert_win_step_R5: assert property (@(posedge clk) disable iff (rst)
        (shift && win_mode) |=> win_q == $past(win_q) + win_t'(1));

    assert_base_hold_R8: assert property (@(posedge clk) disable iff (rst)
        !(shift && !win_mode) |=> $stable(base_q));

    assert_win_hold_R8: assert property (@(posedge clk) disable iff (rst)
        !(shift && win_mode) |=> $stable(win_q));

    assert_win_wrap_R9: assert property (@(posedge clk) disable iff (rst)
        (shift && win_mode && win_q == '1) |=> win_q == '0);
endmodule

bind offset_ring_mem offset_ring_mem_chk #(.STEP(STEP)) u_chk (
    .clk      (clk),
    .rst      (rst),
    .win_mode (win_mode),
    .shift    (shift),
    .base_q   (base_q),
    .win_q    (win_q),
    .rd_data  (rd_data)
);

// File: tb/tb_offset_ring_mem.sv
module tb_offset_ring_mem;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        win_mode = 1'b0;
    logic        shift = 1'b0;
    logic        wr_en = 1'b0;
    logic [9:0]  addr = '0;
    logic [15:0] wr_data = '0;
    logic [15:0] rd_data;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #10 clk = ~clk; // 50 MHz

    offset_ring_mem dut (
        .clk(clk), .rst(rst), .win_mode(win_mode), .shift(shift),
        .wr_en(wr_en), .addr(addr), .wr_data(wr_data), .rd_data(rd_data)
    );

    typedef struct packed {
        logic        md;
        logic        sh;
        logic        wr;
        logic [9:0]  a;
        logic [15:0] d;
        logic        chk;
        logic [15:0] exp;
        logic [3:0]  req;
    } vec_t;

    localparam int NV = 17;
    localparam vec_t TBL [NV] = '{
        '{1'b0, 1'b0, 1'b1, 10'd0,    16'hA000, 1'b0, 16'h0000, 4'd2},
        '{1'b0, 1'b0, 1'b1, 10'd60,   16'hA060, 1'b0, 16'h0000, 4'd2},
        '{1'b0, 1'b0, 1'b1, 10'd1000, 16'hA3E8, 1'b0, 16'h0000, 4'd2},
        '{1'b0, 1'b0, 1'b1, 10'd100,  16'hA100, 1'b0, 16'h0000, 4'd2},
        '{1'b0, 1'b0, 1'b0, 10'd0,    16'h0000, 1'b1, 16'hA000, 4'd2}, // R2 base 0
        '{1'b0, 1'b1, 1'b0, 10'd60,   16'h0000, 1'b1, 16'hA060, 4'd6}, // R6 old base
        '{1'b0, 1'b0, 1'b0, 10'd0,    16'h0000, 1'b1, 16'hA060, 4'd3}, // R3 base 60
        '{1'b0, 1'b0, 1'b0, 10'd40,   16'h0000, 1'b1, 16'hA100, 4'd2}, // R2
        '{1'b0, 1'b0, 1'b0, 10'd964,  16'h0000, 1'b1, 16'hA000, 4'd4}, // R4 964+60 wraps to 0
        '{1'b0, 1'b0, 1'b1, 10'd940,  16'hB000, 1'b1, 16'hA3E8, 4'd7}, // R7 read before write
        '{1'b0, 1'b0, 1'b0, 10'd940,  16'h0000, 1'b1, 16'hB000, 4'd7}, // R7
        '{1'b0, 1'b0, 1'b1, 10'd4,    16'hA040, 1'b0, 16'h0000, 4'd2}, // phys 64
        '{1'b1, 1'b0, 1'b0, 10'd0,    16'h0000, 1'b1, 16'hA000, 4'd5}, // R5 win 0
        '{1'b1, 1'b1, 1'b0, 10'd60,   16'h0000, 1'b1, 16'hA060, 4'd6}, // R6 old win
        '{1'b1, 1'b0, 1'b0, 10'd0,    16'h0000, 1'b1, 16'hA040, 4'd5}, // R5 win 1
        '{1'b1, 1'b0, 1'b0, 10'd960,  16'h0000, 1'b1, 16'hA000, 4'd9}, // R9 15+1 wraps
        '{1'b0, 1'b0, 1'b0, 10'd0,    16'h0000, 1'b1, 16'hA060, 4'd8}  // R8 base kept
    };

    task automatic op(input logic md, input logic sh, input logic wr,
                      input logic [9:0] a, input logic [15:0] d,
                      output logic [15:0] q);
        win_mode = md; shift = sh; wr_en = wr; addr = a; wr_data = d;
        @(negedge clk);
        q = rd_data;
        shift = 1'b0; wr_en = 1'b0;
    endtask

    task automatic check(input string tag, input logic [15:0] act,
                         input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    initial begin
        logic [15:0] q;
        @(negedge clk);
        @(negedge clk);
        check("R1 reset rd_data", rd_data, 16'h0000);
        rst = 1'b0;

        for (int i = 0; i < NV; i++) begin
            op(TBL[i].md, TBL[i].sh, TBL[i].wr, TBL[i].a, TBL[i].d, q);
            if (TBL[i].chk) begin
                checks++;
                if (q !== TBL[i].exp) begin
                    fails++;
                    $display("FAIL R%0d row %0d: actual %h expected %h",
                             TBL[i].req, i, q, TBL[i].exp);
                end
            end
        end

        // R1: reset clears base and window, memory keeps contents
        rst = 1'b1;
        @(negedge clk);
        @(negedge clk);
        check("R1 rd_data in reset", rd_data, 16'h0000);
        rst = 1'b0;
        op(1'b0, 1'b0, 1'b0, 10'd0, 16'h0, q);
        check("R1 base cleared", q, 16'hA000);
        op(1'b1, 1'b0, 1'b0, 10'd0, 16'h0, q);
        check("R1 window cleared", q, 16'hA000);

        // R4: 18 shifts of 60 give base 56; logical 8 -> phys 64
        for (int k = 0; k < 18; k++) op(1'b0, 1'b1, 1'b0, 10'd0, 16'h0, q);
        op(1'b0, 1'b0, 1'b0, 10'd8, 16'h0, q);
        check("R4 accumulated wrap", q, 16'hA040);
        op(1'b1, 1'b0, 1'b0, 10'd0, 16'h0, q);
        check("R8 window unaffected", q, 16'hA000);

        // R9: window counter steps and wraps after 16 shifts
        op(1'b1, 1'b1, 1'b0, 10'd0, 16'h0, q);
        op(1'b1, 1'b0, 1'b0, 10'd0, 16'h0, q);
        check("R5 window step", q, 16'hA040);
        for (int k = 0; k < 15; k++) op(1'b1, 1'b1, 1'b0, 10'd0, 16'h0, q);
        op(1'b1, 1'b0, 1'b0, 10'd0, 16'h0, q);
        check("R9 window wrap", q, 16'hA000);
        op(1'b0, 1'b0, 1'b0, 10'd8, 16'h0, q);
        check("R8 base unaffected", q, 16'hA040);

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end
endmodule